// File: doc/BRIEF.md
# Cartridge ROM Block-Transfer Controller

This controller sits between a host and a cartridge ROM. The host loads eight command bytes, then writes a control word carrying a block-size code, a rate select, an interrupt enable and a start bit. The controller decodes the first command byte. A read command streams a block of 32-bit words from a ROM port into a host-visible data register. An identification command places a fixed chip word in that register. Any other opcode finishes at once.

Words are paced by a down-counter. The first word of a read arrives a fixed number of cycles after the start. Each later word arrives the same number of cycles after the host reads the previous one. When the remaining byte count is exhausted, the next pacing expiry ends the block: it clears the data register and the status flags, and can pulse an interrupt. Control writes are refused while an external SPI-mode level is high.

Top module: `cart_xfer_ctrl`

## Requirements
- R1: After reset, `busy`, `word_ready` and `irq` are 0, `rd_data` is zero and `rom_req` is low.
- R2: Opcode 0xB7 in command byte 0 starts a read. Its start address is command bytes 1..4, with byte 1 the most significant. The first word delivered is the ROM word at that address.
- R3: Block-size code n (control bits `ctl_size`) gives 0x100<<n bytes for n = 1..6, zero words for n = 0 and one 4-byte word for n = 7. `busy` stays high until exactly that many words have been delivered and one further pacing interval has expired.
- R4: A word becomes ready exactly 5 clock edges after the start or host-read edge when `ctl_slow` was 0 at start. With `ctl_slow` = 1 the gap is 8 edges. `word_ready` is low in the cycle before.
- R5: Each delivered word advances the ROM address by 4.
- R6: No further word is fetched until the host pulses `data_rd`. Until then, `rd_data` and `word_ready` hold their values.
- R7: The pacing expiry after the last word sets `rd_data` to zero and clears `word_ready` and `busy`. In that same cycle `irq` is high for exactly one cycle if `ctl_irq_en` was set at start, and stays low otherwise.
- R8: Opcode 0xB8 sets `rd_data` to the CHIP_ID parameter with `word_ready` and `busy` high on the edge after the control write, and fetches nothing from ROM. The block then ends as in R7 one pacing interval after the host read.
- R9: Any other opcode ends at the control-write edge: `busy` and `word_ready` are 0, `rd_data` is all ones and `irq` stays low.
- R10: While `spi_mode` is high, control writes are ignored: `busy` and `rd_data` are unchanged.
- R11: While `busy` is high, command-byte and control writes are ignored, and the running block continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_idx | input | 3 | Command byte index |
| cmd_byte | input | 8 | Command byte value |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_size | input | 3 | Block-size code |
| ctl_slow | input | 1 | Rate select: 1 gives the 8-cycle gap |
| ctl_irq_en | input | 1 | Interrupt enable for block end |
| ctl_start | input | 1 | Start bit |
| spi_mode | input | 1 | Shared port is in SPI mode; control writes refused |
| data_rd | input | 1 | Host read strobe for the data register |
| rd_data | output | 32 | Data register |
| word_ready | output | 1 | A word is waiting in `rd_data` |
| busy | output | 1 | Block in progress |
| irq | output | 1 | One-cycle block-complete pulse |
| rom_req | output | 1 | ROM fetch strobe; `rom_rdata` is sampled in this cycle |
| rom_addr | output | 32 | ROM byte address |
| rom_rdata | input | 32 | ROM word returned combinationally |

## Verification
Every result has a fixed edge count from the edge that sampled its stimulus. Opcode outcomes for 0xB8 and unknown opcodes appear one edge after the control write. A data word appears exactly 5 or 8 edges after the start or read edge, and the block end appears the same interval after the final read. The bench drives and samples at falling edges. It checks `word_ready` low one edge before the due edge and high on it, so a pacing error of one cycle in either direction is caught. Word counts, data values and the interrupt are compared against a bench-side ROM function and size table.

// File: rtl/cart_xfer_pkg.sv
package cart_xfer_pkg;
   localparam logic [7:0] OP_BLOCK_READ = 8'hB7;
   localparam logic [7:0] OP_CHIP_ID    = 8'hB8;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_ID    = 2'd1,
      KIND_OTHER = 2'd2
   } cmd_kind_t;

   function automatic cmd_kind_t classify_op(input logic [7:0] op);
      if (op == OP_BLOCK_READ) return KIND_READ;
      if (op == OP_CHIP_ID)    return KIND_ID;
      return KIND_OTHER;
   endfunction
endpackage

// File: rtl/cart_cmd_regs.sv
module cart_cmd_regs #(
   parameter int NBYTES = 8,
   localparam int IDX_W = $clog2(NBYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_byte,
   output logic [7:0]       opcode,
   output logic [31:0]      start_addr
);
   initial assert (NBYTES >= 5);

   logic [7:0] bytes_q [NBYTES];

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)
            bytes_q[g] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            bytes_q[g] <= wr_byte;
      end
   end

   // byte 1 is the most significant address byte
   assign opcode     = bytes_q[0];
   assign start_addr = {bytes_q[1], bytes_q[2], bytes_q[3], bytes_q[4]};
endmodule

// File: rtl/cart_len_decode.sv
module cart_len_decode #(
   parameter int LEN_W = 15
) (
   input  logic [2:0]       size_code,
   output logic [LEN_W-1:0] len_bytes
);
   initial assert (LEN_W >= 15);

   logic [LEN_W-1:0] len_tbl [8];

   for (genvar g = 0; g < 8; g++) begin : g_len
      if (g == 0) begin : g_none
         assign len_tbl[g] = '0;
      end else if (g == 7) begin : g_single
         assign len_tbl[g] = LEN_W'(4);
      end else begin : g_pow
         assign len_tbl[g] = LEN_W'(256) << g;
      end
   end

   assign len_bytes = len_tbl[size_code];
endmodule

// File: rtl/cart_pace_timer.sv
module cart_pace_timer #(
   parameter int PACE_FAST = 5,
   parameter int PACE_SLOW = 8,
   localparam int CNT_W = $clog2(PACE_SLOW + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic slow,
   output logic fire
);
   initial assert (PACE_FAST >= 2 && PACE_SLOW >= PACE_FAST);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= slow ? CNT_W'(PACE_SLOW) : CNT_W'(PACE_FAST);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   // a reload in the expiring cycle restarts the interval instead
   assign fire = (cnt_q == CNT_W'(1)) && !load;
endmodule

// File: rtl/cart_xfer_ctrl.sv
module cart_xfer_ctrl #(
   parameter int          PACE_FAST = 5,
   parameter int          PACE_SLOW = 8,
   parameter int          LEN_W     = 15,
   parameter logic [31:0] CHIP_ID   = 32'h0000_3FC2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_wr,
   input  logic [2:0]  cmd_idx,
   input  logic [7:0]  cmd_byte,
   input  logic        ctl_wr,
   input  logic [2:0]  ctl_size,
   input  logic        ctl_slow,
   input  logic        ctl_irq_en,
   input  logic        ctl_start,
   input  logic        spi_mode,
   input  logic        data_rd,
   output logic [31:0] rd_data,
   output logic        word_ready,
   output logic        busy,
   output logic        irq,
   output logic        rom_req,
   output logic [31:0] rom_addr,
   input  logic [31:0] rom_rdata
);
   import cart_xfer_pkg::*;

   logic [7:0]       opcode;
   logic [31:0]      cmd_addr;
   logic [LEN_W-1:0] len_bytes;
   logic             pace_fire, pace_load, pace_slow;

   logic [31:0]      data_q, addr_q;
   logic [LEN_W-1:0] rem_q;
   logic             busy_q, ready_q, slow_q, ien_q, irq_q;

   cmd_kind_t kind;
   logic      accept_start, tick;

   cart_cmd_regs #(.NBYTES(8)) u_cmd (
      .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr && !busy_q),
      .wr_idx(cmd_idx), .wr_byte(cmd_byte),
      .opcode(opcode), .start_addr(cmd_addr)
   );

   cart_len_decode #(.LEN_W(LEN_W)) u_len (
      .size_code(ctl_size), .len_bytes(len_bytes)
   );

   cart_pace_timer #(.PACE_FAST(PACE_FAST), .PACE_SLOW(PACE_SLOW)) u_pace (
      .clk(clk), .rst_n(rst_n), .load(pace_load), .slow(pace_slow),
      .fire(pace_fire)
   );

   assign kind         = classify_op(opcode);
   assign accept_start = ctl_wr && ctl_start && !spi_mode && !busy_q;
   assign pace_load    = (accept_start && kind == KIND_READ) || (data_rd && busy_q);
   assign pace_slow    = accept_start ? ctl_slow : slow_q;
   assign tick         = pace_fire && busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         addr_q  <= '0;
         rem_q   <= '0;
         busy_q  <= 1'b0;
         ready_q <= 1'b0;
         slow_q  <= 1'b0;
         ien_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (accept_start) begin
            slow_q <= ctl_slow;
            ien_q  <= ctl_irq_en;
            case (kind)
               KIND_READ: begin
                  busy_q  <= 1'b1;
                  ready_q <= 1'b0;
                  data_q  <= '0;
                  addr_q  <= cmd_addr;
                  rem_q   <= len_bytes;
               end
               KIND_ID: begin
                  busy_q  <= 1'b1;
                  ready_q <= 1'b1;
                  data_q  <= CHIP_ID;
                  rem_q   <= '0;
               end
               default: begin
                  busy_q  <= 1'b0;
                  ready_q <= 1'b0;
                  data_q  <= '1;
                  rem_q   <= '0;
               end
            endcase
         end else if (tick) begin
            if (rem_q != '0) begin
               data_q  <= rom_rdata;
               addr_q  <= addr_q + 32'd4;
               rem_q   <= rem_q - LEN_W'(4);
               ready_q <= 1'b1;
            end else begin
               data_q  <= '0;
               ready_q <= 1'b0;
               busy_q  <= 1'b0;
               irq_q   <= ien_q;
            end
         end else if (data_rd && busy_q) begin
            ready_q <= 1'b0;
         end
      end
   end

   assign rd_data    = data_q;
   assign word_ready = ready_q;
   assign busy       = busy_q;
   assign irq        = irq_q;
   assign rom_req    = tick && (rem_q != '0);
   assign rom_addr   = addr_q;

   AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!busy && $past(busy))) else $error("irq outside block end"); // R7
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq) else $error("irq longer than one cycle"); // R7
   AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      word_ready |-> busy) else $error("ready while idle"); // R3
   AST_FETCH_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req |-> busy) else $error("fetch while idle"); // R3
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req |=> (rom_addr == $past(rom_addr) + 32'd4)) else $error("address step"); // R5
   AST_SPI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctl_wr && spi_mode) |=> !busy) else $error("start in spi mode"); // R10
   AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (word_ready && !data_rd) |=> ($stable(rd_data) && word_ready)) else $error("word lost"); // R6
endmodule

// File: tb/tb_cart_xfer_ctrl.sv
module tb_cart_xfer_ctrl;
   localparam logic [31:0] CHIP = 32'h0000_3FC2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_wr = 0, ctl_wr = 0, ctl_slow = 0, ctl_irq_en = 0, ctl_start = 0;
   logic spi_mode = 0, data_rd = 0;
   logic [2:0] cmd_idx = 0, ctl_size = 0;
   logic [7:0] cmd_byte = 0;
   logic [31:0] rd_data, rom_addr, rom_rdata;
   logic word_ready, busy, irq, rom_req;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   function automatic logic [31:0] rom_word(input logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
   endfunction

   function automatic int words_for(input int code);
      if (code == 0) return 0;
      if (code == 7) return 1;
      return (256 << code) / 4;
   endfunction

   assign rom_rdata = rom_word(rom_addr);

   cart_xfer_ctrl #(.CHIP_ID(CHIP)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_idx(cmd_idx),
      .cmd_byte(cmd_byte), .ctl_wr(ctl_wr), .ctl_size(ctl_size),
      .ctl_slow(ctl_slow), .ctl_irq_en(ctl_irq_en), .ctl_start(ctl_start),
      .spi_mode(spi_mode), .data_rd(data_rd), .rd_data(rd_data),
      .word_ready(word_ready), .busy(busy), .irq(irq), .rom_req(rom_req),
      .rom_addr(rom_addr), .rom_rdata(rom_rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic put_cmd(input logic [7:0] b0, input logic [31:0] a);
      for (int i = 0; i < 5; i++) begin
         cmd_wr = 1; cmd_idx = 3'(i);
         cmd_byte = (i == 0) ? b0 : a[8*(4-i) +: 8];
         edges(1);
      end
      cmd_wr = 0;
   endtask

   task automatic put_ctl(input int code, input bit slow, input bit ien);
      ctl_wr = 1; ctl_start = 1; ctl_size = 3'(code);
      ctl_slow = slow; ctl_irq_en = ien;
      edges(1);
      ctl_wr = 0; ctl_start = 0;
   endtask

   task automatic host_read();
      data_rd = 1;
      edges(1);
      data_rd = 0;
   endtask

   // wait out one pacing interval from the last sampled edge, checking the edge before
   task automatic pace_wait(input int pace, input bit end_of_block);
      edges(pace - 1);
      if (end_of_block) chk(busy === 1'b1, "R3 no early end", {31'd0, busy}, 1);
      else chk(word_ready === 1'b0, "R4 ready early", {31'd0, word_ready}, 0);
      edges(1);
   endtask

   task automatic run_read(input logic [31:0] a, input int code, input bit slow,
                           input bit ien, input bit poke);
      int pace = slow ? 8 : 5;
      int nw = words_for(code);
      put_cmd(8'hB7, a);
      put_ctl(code, slow, ien);
      chk(busy === 1'b1, "R2 busy after start", {31'd0, busy}, 1);
      for (int k = 0; k < nw; k++) begin
         pace_wait(pace, 0);
         chk(word_ready === 1'b1, "R4 ready on time", {31'd0, word_ready}, 1);
         chk(rd_data === rom_word(a + 32'(4 * k)), k == 0 ? "R2 first word" : "R5 word",
             rd_data, rom_word(a + 32'(4 * k)));
         if (k == 0) begin
            edges(6);
            chk(word_ready === 1'b1 && rd_data === rom_word(a), "R6 held without read",
                rd_data, rom_word(a));
            if (poke) begin
               put_cmd(8'h00, 32'hFFFF_FFFF);
               put_ctl(7, 0, 0);
               chk(busy === 1'b1 && rd_data === rom_word(a), "R11 write during busy",
                   rd_data, rom_word(a));
            end
         end
         host_read();
         chk(word_ready === 1'b0, "R6 ready cleared by read", {31'd0, word_ready}, 0);
      end
      pace_wait(pace, 1);
      chk(busy === 1'b0, "R3 busy cleared after count", {31'd0, busy}, 0);
      chk(word_ready === 1'b0 && rd_data === 32'd0, "R7 end data zero", rd_data, 0);
      chk(irq === ien, "R7 irq at end", {31'd0, irq}, {31'd0, ien});
      edges(1);
      chk(irq === 1'b0, "R7 irq one cycle", {31'd0, irq}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0C0FFEE5));
      edges(3);
      rst_n = 1;
      edges(1);
      chk(busy === 0 && word_ready === 0 && irq === 0 && rom_req === 0,
          "R1 reset flags", {28'd0, busy, word_ready, irq, rom_req}, 0);
      chk(rd_data === 32'd0, "R1 reset data", rd_data, 0);

      // R3 code 0: no words; code 7: one word; code 1 with fast and slow rates
      run_read(32'h0000_1000, 0, 0, 1, 0);
      run_read(32'h1234_5678, 7, 1, 1, 1);
      run_read(32'hA0B0_C0D0, 1, 0, 0, 0);
      run_read(32'h0100_0200, 1, 1, 1, 0);

      // R8 chip identifier
      put_cmd(8'hB8, 32'd0);
      put_ctl(2, 1, 1);
      chk(rd_data === CHIP && word_ready === 1 && busy === 1, "R8 chip id", rd_data, CHIP);
      chk(rom_req === 1'b0, "R8 no fetch", {31'd0, rom_req}, 0);
      host_read();
      pace_wait(8, 1);
      chk(busy === 0 && rd_data === 0, "R8 end after read", rd_data, 0);
      chk(irq === 1'b1, "R8 irq", {31'd0, irq}, 1);

      // R9 unknown opcode
      put_cmd(8'h3C, 32'hDEAD_BEEF);
      put_ctl(3, 0, 1);
      chk(busy === 0 && word_ready === 0 && rd_data === 32'hFFFF_FFFF,
          "R9 unknown opcode", rd_data, 32'hFFFF_FFFF);
      edges(1);
      chk(irq === 1'b0, "R9 no irq", {31'd0, irq}, 0);

      // R10 spi mode refuses the control write
      put_cmd(8'hB7, 32'h0000_0040);
      spi_mode = 1;
      put_ctl(1, 0, 1);
      edges(10);
      chk(busy === 0 && rd_data === 32'hFFFF_FFFF, "R10 spi ignore", rd_data, 32'hFFFF_FFFF);
      spi_mode = 0;

      // constrained random reads
      for (int t = 0; t < 10; t++) begin
         run_read($urandom(), int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule